// File: doc/BRIEF.md
# Four-Channel DMA Bus Ownership Arbiter

This block decides which of four DMA channels may use the shared system bus. The channels are receive A, transmit A, receive B and transmit B. Each request is first gated by its own enable bit. While at least one gated request is pending, the block raises a bus request. It then waits for the bus grant, picks a winner and shows the winner on a one-hot owner output for as long as it holds the bus.

A 2-bit selector picks one of four fixed priority orderings. Two of them rank the serial channels first (A before B, or B before A). The other two rank direction first (all receives before all transmits). A mode input picks how the bus is handed on at the end of each transfer:
- In hold mode the bus stays owned and passes directly to the next pending channel.
- In release mode the bus is always dropped and then requested again.

A new choice is made only when a transfer ends. The end of a transfer is marked by a one-cycle done pulse.

Top module: `dma_bus_arbiter`

## Requirements
- R1: While reset is high, and in the first cycle after it, `bus_req_o` is 0 and `active_o` is all zeros.
- R2: A request whose enable bit is 0 is never considered. Bit i of `chan_en_i` gates bit i of `req_i`. Bit 0 is receive A, bit 1 transmit A, bit 2 receive B, bit 3 transmit B. With only disabled requests pending, `bus_req_o` stays 0. The owner is always an enabled requester.
- R3: When the bus is free and an enabled request is pending at a clock edge, `bus_req_o` is 1 after that edge. `active_o` stays all zeros until `bus_grant_i` is seen high.
- R4: At the first edge where `bus_grant_i` is high during a bus request, the highest-priority enabled pending channel becomes owner. Its one-hot bit appears on `active_o` after that edge.
- R5: Priority code 00 ranks receive A, transmit A, receive B, transmit B, from highest to lowest.
- R6: Priority code 01 ranks receive B, transmit B, receive A, transmit A.
- R7: Priority code 10 ranks receive A, receive B, transmit A, transmit B.
- R8: Priority code 11 ranks receive B, receive A, transmit B, transmit A.
- R9: Hold mode (`release_mode_i` = 0) with an enabled request pending at the done pulse: `bus_req_o` stays 1, and the newly chosen owner appears on `active_o` after that edge.
- R10: Hold mode with no enabled request pending at the done pulse: `bus_req_o` and `active_o` both go to 0 after that edge.
- R11: Release mode (`release_mode_i` = 1): after each done pulse, `bus_req_o` and `active_o` are 0 for at least one cycle. If requests are still pending, the bus is then requested again, and a new owner is chosen only after a grant.
- R12: Between done pulses `active_o` does not change. A change of priority code, mode or requests made during ownership is used only at the next done pulse.
- R13: `active_o` never has more than one bit set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_i | input | 4 | Per-channel DMA requests (RxA, TxA, RxB, TxB at bits 0..3) |
| chan_en_i | input | 4 | Per-channel enable mask, same bit order |
| prio_sel_i | input | 2 | Priority ordering code |
| release_mode_i | input | 1 | 1: release the bus after every transfer; 0: hold it while requests remain |
| bus_grant_i | input | 1 | Bus grant from the system bus master |
| xfer_done_i | input | 1 | One-cycle pulse marking the end of the owner's transfer |
| bus_req_o | output | 1 | Registered bus request |
| active_o | output | 4 | Registered one-hot current owner, zero when the bus is not owned |

## Verification
The hardest case to reach is a settings change during ownership: a new priority code or mode has to be ignored until the next done pulse, and then used at that pulse. The stimulus creates this case on purpose. It grants the bus to a channel with three channels pending and then flips both the priority code and the mode over several cycles. The active owner must stay the same throughout. The stimulus then sets the mode back to hold and ends the transfer, so the next owner must follow the new ordering. Finally it selects release mode and ends the transfer again with a request still pending, so the bus must be dropped.

// File: rtl/dma_arb_pkg.sv
package dma_arb_pkg;

  localparam int NCH   = 4;
  localparam int IDX_W = 2;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_REQ  = 2'd1,
    ST_OWN  = 2'd2
  } own_state_e;

  // Channel index layout: bit 1 = serial port (0:A 1:B), bit 0 = direction (0:rx 1:tx).
  // sel[1] picks port-major (0) or direction-major (1) ranking; sel[0] puts B first.
  function automatic logic [IDX_W-1:0] rank_to_chan(input logic [1:0] sel,
                                                    input logic [IDX_W-1:0] rank);
    logic [IDX_W-1:0] base;
    base = sel[1] ? {rank[0], rank[1]} : rank;
    return base ^ {sel[0], 1'b0};
  endfunction

endpackage

// File: rtl/dma_req_mask.sv
module dma_req_mask #(
  parameter int N_CH = dma_arb_pkg::NCH
) (
  input  logic [N_CH-1:0] req_i,
  input  logic [N_CH-1:0] en_i,
  output logic [N_CH-1:0] pend_o,
  output logic            any_o
);

  always_comb begin
    pend_o = req_i & en_i;
    any_o  = |pend_o;
  end

endmodule

// File: rtl/dma_prio_pick.sv
module dma_prio_pick
  import dma_arb_pkg::*;
#(
  parameter int N_CH = NCH
) (
  input  logic [N_CH-1:0] pend_i,
  input  logic [1:0]      prio_i,
  output logic [N_CH-1:0] win_o
);

  logic [IDX_W-1:0] cand_ch [N_CH];

  for (genvar r = 0; r < N_CH; r++) begin : g_rank
    assign cand_ch[r] = rank_to_chan(prio_i, IDX_W'(r));
  end

  // Walk ranks from lowest to highest so the highest-ranked pending one wins.
  always_comb begin
    win_o = '0;
    for (int r = N_CH - 1; r >= 0; r--) begin
      if (pend_i[cand_ch[r]]) begin
        win_o = '0;
        win_o[cand_ch[r]] = 1'b1;
      end
    end
  end

endmodule

// File: rtl/dma_own_fsm.sv
module dma_own_fsm
  import dma_arb_pkg::*;
#(
  parameter int N_CH = NCH
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            any_pend_i,
  input  logic [N_CH-1:0] win_i,
  input  logic            release_mode_i,
  input  logic            bus_grant_i,
  input  logic            xfer_done_i,
  output logic            bus_req_o,
  output logic [N_CH-1:0] active_o
);

  own_state_e state_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q   <= ST_IDLE;
      bus_req_o <= 1'b0;
      active_o  <= '0;
    end else begin
      case (state_q)
        ST_IDLE: begin
          if (any_pend_i) begin
            state_q   <= ST_REQ;
            bus_req_o <= 1'b1;
          end
        end
        ST_REQ: begin
          if (bus_grant_i) begin
            if (any_pend_i) begin
              state_q  <= ST_OWN;
              active_o <= win_i;
            end else begin
              state_q   <= ST_IDLE;
              bus_req_o <= 1'b0;
            end
          end
        end
        ST_OWN: begin
          if (xfer_done_i) begin
            if (!release_mode_i && any_pend_i) begin
              active_o <= win_i;
            end else begin
              state_q   <= ST_IDLE;
              bus_req_o <= 1'b0;
              active_o  <= '0;
            end
          end
        end
        default: begin
          state_q   <= ST_IDLE;
          bus_req_o <= 1'b0;
          active_o  <= '0;
        end
      endcase
    end
  end

  assert_onehot_owner_R13: assert property (@(posedge clk) disable iff (rst)
    $onehot0(active_o));

  assert_owner_has_req_R4: assert property (@(posedge clk) disable iff (rst)
    (|active_o) |-> bus_req_o);

  assert_owner_stable_R12: assert property (@(posedge clk) disable iff (rst)
    ((|active_o) && !xfer_done_i) |=> $stable(active_o));

  assert_release_gap_R11: assert property (@(posedge clk) disable iff (rst)
    ((|active_o) && xfer_done_i && release_mode_i) |=> (!bus_req_o && active_o == '0));

  assert_hold_handoff_R9: assert property (@(posedge clk) disable iff (rst)
    ((|active_o) && xfer_done_i && !release_mode_i && any_pend_i) |=> (bus_req_o && (|active_o)));

  assert_hold_drop_R10: assert property (@(posedge clk) disable iff (rst)
    ((|active_o) && xfer_done_i && !any_pend_i) |=> (!bus_req_o && active_o == '0));

  assert_wait_grant_R3: assert property (@(posedge clk) disable iff (rst)
    (bus_req_o && active_o == '0 && !bus_grant_i) |=> (active_o == '0));

endmodule

// File: rtl/dma_bus_arbiter.sv
module dma_bus_arbiter
  import dma_arb_pkg::*;
#(
  parameter int N_CH = NCH
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [N_CH-1:0] req_i,
  input  logic [N_CH-1:0] chan_en_i,
  input  logic [1:0]      prio_sel_i,
  input  logic            release_mode_i,
  input  logic            bus_grant_i,
  input  logic            xfer_done_i,
  output logic            bus_req_o,
  output logic [N_CH-1:0] active_o
);

  logic [N_CH-1:0] pend;
  logic            any_pend;
  logic [N_CH-1:0] win;

  dma_req_mask #(.N_CH(N_CH)) u_mask (
    .req_i  (req_i),
    .en_i   (chan_en_i),
    .pend_o (pend),
    .any_o  (any_pend)
  );

  dma_prio_pick #(.N_CH(N_CH)) u_pick (
    .pend_i (pend),
    .prio_i (prio_sel_i),
    .win_o  (win)
  );

  dma_own_fsm #(.N_CH(N_CH)) u_fsm (
    .clk            (clk),
    .rst            (rst),
    .any_pend_i     (any_pend),
    .win_i          (win),
    .release_mode_i (release_mode_i),
    .bus_grant_i    (bus_grant_i),
    .xfer_done_i    (xfer_done_i),
    .bus_req_o      (bus_req_o),
    .active_o       (active_o)
  );

  assert_win_enabled_R2: assert property (@(posedge clk) disable iff (rst)
    (|win) |-> ((win & req_i & chan_en_i) == win));

  assert_win_when_pending_R4: assert property (@(posedge clk) disable iff (rst)
    ((req_i & chan_en_i) != '0) |-> $onehot(win));

endmodule

// File: tb/dma_bus_arbiter_bench.sv
`timescale 1ns/1ps
module dma_bus_arbiter_bench;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [3:0] req = '0;
  logic [3:0] en = '0;
  logic [1:0] prio = '0;
  logic       rel_mode = 1'b0;
  logic       grant = 1'b0;
  logic       done = 1'b0;
  logic       bus_req;
  logic [3:0] active;

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  dma_bus_arbiter u_dma_bus_arbiter (
    .clk(clk), .rst(rst), .req_i(req), .chan_en_i(en), .prio_sel_i(prio),
    .release_mode_i(rel_mode), .bus_grant_i(grant), .xfer_done_i(done),
    .bus_req_o(bus_req), .active_o(active)
  );

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic check(input bit ok, input string tag, input logic [4:0] act, input logic [4:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%b expected=%b", tag, act, exp);
    end
  endtask

  task automatic chk_out(input string tag, input logic exp_req, input logic [3:0] exp_act);
    check(bus_req === exp_req && active === exp_act, tag, {bus_req, active}, {exp_req, exp_act});
  endtask

  task automatic pulse_done();
    done = 1'b1;
    tick();
    done = 1'b0;
  endtask

  task automatic finish_own();
    req = '0;
    pulse_done();
    grant = 1'b0;
    tick();
  endtask

  task automatic t_reset();
    tick();
    chk_out("R1 in reset", 1'b0, 4'b0000);
    rst = 1'b0;
    tick();
    chk_out("R1 after reset", 1'b0, 4'b0000);
  endtask

  task automatic t_disabled();
    en = 4'b0011; req = 4'b1100; prio = 2'b01; rel_mode = 1'b0;
    repeat (4) tick();
    chk_out("R2 disabled only", 1'b0, 4'b0000);
    req = 4'b1111;
    tick();
    chk_out("R2 request raised", 1'b1, 4'b0000);
    grant = 1'b1;
    tick();
    chk_out("R2 enabled winner", 1'b1, 4'b0001);
    finish_own();
    chk_out("R2 released", 1'b0, 4'b0000);
  endtask

  task automatic t_grant_wait();
    en = 4'b1111; prio = 2'b00; req = 4'b0010;
    tick();
    chk_out("R3 request rises", 1'b1, 4'b0000);
    repeat (5) tick();
    chk_out("R3 no owner without grant", 1'b1, 4'b0000);
    grant = 1'b1;
    tick();
    chk_out("R4 owner after grant", 1'b1, 4'b0010);
    finish_own();
  endtask

  task automatic t_order(input logic [1:0] code, input logic [15:0] seq, input string tag);
    logic [3:0] cur;
    en = 4'b1111; rel_mode = 1'b0; prio = code; req = 4'b1111; grant = 1'b0;
    tick();
    chk_out({tag, " R3 request"}, 1'b1, 4'b0000);
    grant = 1'b1;
    tick();
    chk_out({tag, " first"}, 1'b1, seq[3:0]);
    cur = seq[3:0];
    for (int i = 1; i < 4; i++) begin
      req = req & ~cur;
      pulse_done();
      chk_out({tag, " R9 next"}, 1'b1, seq[4*i +: 4]);
      cur = seq[4*i +: 4];
    end
    req = '0;
    pulse_done();
    chk_out({tag, " R10 drop"}, 1'b0, 4'b0000);
    grant = 1'b0;
    tick();
  endtask

  task automatic t_release();
    en = 4'b1111; prio = 2'b00; rel_mode = 1'b1; req = 4'b0011; grant = 1'b1;
    tick();
    chk_out("R11 request", 1'b1, 4'b0000);
    tick();
    chk_out("R11 first owner", 1'b1, 4'b0001);
    req = 4'b0010;
    pulse_done();
    chk_out("R11 gap", 1'b0, 4'b0000);
    tick();
    chk_out("R11 re-request", 1'b1, 4'b0000);
    tick();
    chk_out("R11 second owner", 1'b1, 4'b0010);
    finish_own();
    chk_out("R11 idle", 1'b0, 4'b0000);
    rel_mode = 1'b0;
  endtask

  task automatic t_midchange();
    en = 4'b1111; prio = 2'b00; rel_mode = 1'b0; req = 4'b0111; grant = 1'b1;
    tick();
    tick();
    chk_out("R12 owner", 1'b1, 4'b0001);
    prio = 2'b01; rel_mode = 1'b1;
    repeat (3) tick();
    chk_out("R12 stable after change", 1'b1, 4'b0001);
    rel_mode = 1'b0; req = 4'b0110;
    pulse_done();
    chk_out("R12 new order at done", 1'b1, 4'b0100);
    rel_mode = 1'b1; req = 4'b0010;
    tick();
    chk_out("R12 stable mid", 1'b1, 4'b0100);
    pulse_done();
    chk_out("R12 new mode at done", 1'b0, 4'b0000);
    req = '0; grant = 1'b0; rel_mode = 1'b0;
    repeat (2) tick();
  endtask

  initial begin
    t_reset();
    t_disabled();
    t_grant_wait();
    t_order(2'b00, 16'b1000_0100_0010_0001, "R5");
    t_order(2'b01, 16'b0010_0001_1000_0100, "R6");
    t_order(2'b10, 16'b1000_0010_0100_0001, "R7");
    t_order(2'b11, 16'b0010_1000_0001_0100, "R8");
    t_release();
    t_midchange();
    if (!finished) begin
      finished = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

endmodule